// File: doc/BRIEF.md
# Zero-Count Threshold Detector

This block looks at a 16-bit data word and reports how many of its bits are zero, reduced to two alarm levels. The low-level flag rises when more than 7 bits are clear. The high-level flag rises when more than 11 bits are clear. A typical use is deciding, from a word about to be written, how much programming drive a non-volatile memory needs. The flags could, for example, switch on one or two charge pumps. The pumps themselves are not part of this block.

Internally every bit is inverted, so that a zero counts as one. Adjacent inverted bits are summed in pairs by half adders. The pair sums are then folded through a binary tree of wider adders into one 5-bit zero count. That count is compared against the two thresholds. A parameter chooses whether the flags leave through a clocked register, which has a synchronous active-high clear, or leave directly from the comparators.

Top module: `zero_flag_detect`

## Requirements
- R1: The block counts the input bits that equal 0, over all 16 bits of `din`, and this count is the only quantity the flags depend on.
- R2: `gt_lo` is 1 exactly when the zero count exceeds 7 (count of 8 or more), and 0 otherwise.
- R3: `gt_hi` is 1 exactly when the zero count exceeds 11 (count of 12 or more), and 0 otherwise.
- R4: An all-zero word (count 16) is counted without wrap-around and sets both `gt_lo` and `gt_hi`.
- R5: `gt_hi` equal to 1 implies `gt_lo` equal to 1, for every input and in every cycle.
- R6: With the output register enabled (default), both flags show the word that was sampled at the previous rising edge of `clk`, so the latency is one cycle.
- R7: When `rst` is 1 at a rising edge, both flags are 0 after that edge, whatever `din` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high clear of the flags |
| din | input | 16 | Word whose zero bits are counted |
| gt_lo | output | 1 | Zero count is above 7 |
| gt_hi | output | 1 | Zero count is above 11 |

## Verification
On every clock, the assertions compare each registered flag with a zero count taken from the previous input word. They also check that the high flag never appears without the low flag, that an all-zero word sets both flags, and that reset clears them. The bench's scenarios cover the rest. It walks the full 65,536-word input space with a one-cycle pipeline, so every count from 0 to 16 is exercised. It also applies directed words at counts 7, 8, 11, 12 and 16, and it holds reset against an all-zero word to show that the clear overrides the input.

// File: rtl/zero_flag_detect.sv
module zero_flag_detect #(
  parameter int DATA_W  = 16,
  parameter int LO_THR  = 7,
  parameter int HI_THR  = 11,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic              gt_lo,
  output logic              gt_hi
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int HALF  = DATA_W / 2;

  // node[1] is the root; nodes HALF..DATA_W-1 are the pairwise half adders
  logic [DATA_W-1:0] zbit;
  logic [CNT_W-1:0]  node [1:DATA_W-1];
  logic              lo_c, hi_c;

  assign zbit = ~din;

  genvar i;
  generate
    for (i = HALF; i < DATA_W; i++) begin : g_ha
      logic s, c;
      assign s = zbit[2*i-DATA_W] ^ zbit[2*i-DATA_W+1];
      assign c = zbit[2*i-DATA_W] & zbit[2*i-DATA_W+1];
      assign node[i] = {{(CNT_W-2){1'b0}}, c, s};
    end
    for (i = 1; i < HALF; i++) begin : g_add
      assign node[i] = node[2*i] + node[2*i+1];
    end
  endgenerate

  assign lo_c = node[1] > CNT_W'(LO_THR);
  assign hi_c = node[1] > CNT_W'(HI_THR);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          gt_lo <= 1'b0;
          gt_hi <= 1'b0;
        end else begin
          gt_lo <= lo_c;
          gt_hi <= hi_c;
        end
      end
    end else begin : g_comb
      assign gt_lo = lo_c;
      assign gt_hi = hi_c;
    end
  endgenerate

endmodule

// File: rtl/zero_flag_detect_chk.sv
module zero_flag_detect_chk #(
  parameter int DATA_W  = 16,
  parameter int LO_THR  = 7,
  parameter int HI_THR  = 11,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic              gt_lo,
  input logic              gt_hi
);

  // R5
  a_r5_hi_implies_lo: assert property (@(posedge clk) disable iff (rst)
    gt_hi |-> gt_lo);

  generate
    if (REG_OUT) begin : g_reg
      // R7
      a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!gt_lo && !gt_hi));
      // R2, R6
      a_r2_lo_matches_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gt_lo == ((DATA_W - $countones($past(din))) > LO_THR)));
      // R3, R6
      a_r3_hi_matches_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (gt_hi == ((DATA_W - $countones($past(din))) > HI_THR)));
      // R4
      a_r4_all_zero_sets_both: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(din) == '0)) |-> (gt_lo && gt_hi));
    end else begin : g_comb
      a_r2_lo_matches_count: assert property (@(posedge clk) disable iff (rst)
        gt_lo == ((DATA_W - $countones(din)) > LO_THR));
      a_r3_hi_matches_count: assert property (@(posedge clk) disable iff (rst)
        gt_hi == ((DATA_W - $countones(din)) > HI_THR));
      a_r4_all_zero_sets_both: assert property (@(posedge clk) disable iff (rst)
        (din == '0) |-> (gt_lo && gt_hi));
    end
  endgenerate

endmodule

bind zero_flag_detect zero_flag_detect_chk #(
  .DATA_W(DATA_W), .LO_THR(LO_THR), .HI_THR(HI_THR), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst(rst), .din(din), .gt_lo(gt_lo), .gt_hi(gt_hi)
);

// File: tb/sim_zero_flag_detect.sv
`timescale 1ns/1ps
module sim_zero_flag_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = 16'hFFFF;
  logic        gt_lo, gt_hi;
  int          total = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  zero_flag_detect u0 (.clk(clk), .rst(rst), .din(din), .gt_lo(gt_lo), .gt_hi(gt_hi));

  // {word, expected zero count}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {16'hFFFF, 5'd0},  {16'h0000, 5'd16}, {16'hFF00, 5'd8},  {16'h01FF, 5'd7},
    {16'h000F, 5'd12}, {16'h001F, 5'd11}, {16'h0001, 5'd15}, {16'hAAAA, 5'd8},
    {16'h7FFF, 5'd1},  {16'h0007, 5'd13}, {16'h1F0F, 5'd7},  {16'h0F00, 5'd12}
  };

  function automatic int zeros(input logic [15:0] w);
    int n = 0;
    for (int b = 0; b < 16; b++) if (!w[b]) n++;
    return n;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input logic [15:0] w);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s din=%h actual=%b expected=%b", req, w, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk) din = w;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R7: reset against an all-zero word
    din = 16'h0000;
    repeat (3) @(negedge clk);
    check("R7 lo in reset", gt_lo, 1'b0, din);
    check("R7 hi in reset", gt_hi, 1'b0, din);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R4 lo after release", gt_lo, 1'b1, din);
    check("R4 hi after release", gt_hi, 1'b1, din);

    // R2 R3 R4: directed table including counts 7, 8, 11, 12, 16
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][20:5]);
      check("R2 table lo", gt_lo, VEC[v][4:0] > 5'd7, VEC[v][20:5]);
      check("R3 table hi", gt_hi, VEC[v][4:0] > 5'd11, VEC[v][20:5]);
    end

    // R1 R5 R6: exhaustive sweep, one word per cycle, result one cycle later
    @(negedge clk) din = 16'h0000;
    for (int k = 1; k <= 65536; k++) begin
      logic [15:0] prev;
      prev = din;
      @(negedge clk);
      check("R1 sweep lo", gt_lo, zeros(prev) > 7, prev);
      check("R1 sweep hi", gt_hi, zeros(prev) > 11, prev);
      if (gt_hi && !gt_lo) check("R5 hi without lo", gt_lo, 1'b1, prev);
      din = 16'(k);
    end

    // R6: one-cycle latency (flags still show previous word before the edge)
    @(negedge clk) din = 16'hFFFF;
    @(negedge clk) din = 16'h0000;
    #1 check("R6 old value held", gt_hi, 1'b0, din);
    @(negedge clk);
    check("R6 new value after edge", gt_hi, 1'b1, din);

    // R7: synchronous reset clears while input stays all-zero
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R7 sync clear lo", gt_lo, 1'b0, din);
    check("R7 sync clear hi", gt_hi, 1'b0, din);
    rst = 1'b0;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule